// File: doc/BRIEF.md
# Transmit Driver Activity Monitor

This block watches the transmit line drivers of an eight-channel line interface and flags any driver that has gone quiet. For every channel it receives two pulse indications, one for the positive rail and one for the negative rail, sampled on the line clock. A channel counts consecutive clock cycles in which neither rail carries a pulse. When that silence runs longer than the configured limit, the channel's failure flag rises. The flag then stays high until a pulse appears on that channel again.

The failure flags drive a per-channel output vector directly, so they can feed a pin. The same flags can also be read as a status register. Every change of a flag, rising or falling, latches a sticky per-channel pending bit. A per-channel enable selects which pending bits drive the single interrupt output. Software reads status, enable and pending through a small register port, and it clears pending bits by writing ones to them.

Top module: `txdrv_activity_monitor`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block clears all idle counters, all failure flags, all pending bits and all enable bits. After that edge, drv_fail, irq and every readable register are zero.
- R2: After reset or after a pulse, a channel's drv_fail bit rises at the clock edge that samples the 129th consecutive cycle with neither tx_pos nor tx_neg high on that channel. After only 128 such cycles it is still low.
- R3: A cycle with tx_pos or tx_neg high on a channel counts as a pulse, and either rail alone is enough. The pulse restarts that channel's idle count from zero. If the flag was set, drv_fail for that channel is low after the edge that samples the pulse.
- R4: While a channel stays silent, its failure flag stays set for any length of silence. The idle count saturates and never wraps back to a healthy state.
- R5: Channels are independent. Pulses, silence and flag changes on one channel do not affect the flag or pending bit of another channel.
- R6: Every change of a channel's failure flag, in either direction, sets that channel's pending bit at the same clock edge. The enable bit does not gate this.
- R7: Writing to address 2 (the pending register) clears each pending bit whose data bit is 1. A data bit of 0 leaves the pending bit unchanged. A pending bit never clears in any other way.
- R8: If a flag change and a clearing write reach the same pending bit at the same edge, the pending bit stays set.
- R9: Address 1 holds the per-channel enable bits and can be read and written. irq is high exactly when some channel has both its pending bit and its enable bit set.
- R10: Address 0 reads the failure flags, with bit i for channel i. Address 3 reads as zero. Writes to address 0 or address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_pos | input | 8 | Positive-rail pulse indication, one bit per channel |
| tx_neg | input | 8 | Negative-rail pulse indication, one bit per channel |
| drv_fail | output | 8 | Per-channel driver failure flag |
| irq | output | 1 | Interrupt, OR of enabled pending bits |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 pending, 3 unused |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
On every cycle, the assertions tie each failure flag to an independent count of idle cycles, so a flag that is early, late or spurious is caught. They also check that a pulse on either rail clears the flag at the next edge and that a flag stays set through silence. On the pending side, they check that every flag change sets the pending bit and that pending bits fall only under a clearing write. The interrupt combination, the register read map, the ignored writes and the collision between an edge and a clear are shown through the bench's scenarios, where a reference model tracks enables and pending bits across random pulse densities and register traffic.

// File: rtl/txmon_pkg.sv
// Package: shared register address map for the transmit driver activity monitor.
// Assumes a two-bit register address; the unused code reads as zero.
package txmon_pkg;
    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_STATUS  = 2'd0,
        REG_ENABLE  = 2'd1,
        REG_PENDING = 2'd2,
        REG_SPARE   = 2'd3
    } txmon_reg_e;
endpackage

// File: rtl/txmon_idle_channel.sv
// Module: one channel of the activity monitor.
// Counts consecutive cycles with no pulse on either rail. It raises the failure
// flag on the idle cycle that follows IDLE_LIMIT idle cycles already counted, and
// clears the flag on the edge that samples a pulse. It also reports a flag change
// one cycle ahead, so the edge lines up with the flag update.
// Assumes pulse indications are synchronous to clk.
module txmon_idle_channel #(
    parameter int IDLE_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_pulse,
    input  logic neg_pulse,
    output logic fail,
    output logic fail_change
);
    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_LIMIT);

    logic             pulse_seen;
    logic [CNT_W-1:0] idle_cnt_q;
    logic             fail_q;
    logic             fail_d;

    // Purpose: either rail active marks a valid pulse in this cycle.
    assign pulse_seen = pos_pulse | neg_pulse;

    // Purpose: next failure state: clear on pulse, set once the window is used up, else hold.
    always_comb begin
        if (pulse_seen) begin
            fail_d = 1'b0;
        end else begin
            fail_d = fail_q | (idle_cnt_q == CNT_TOP);
        end
    end

    // Purpose: saturating idle counter, restarted by any pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
        end else if (pulse_seen) begin
            idle_cnt_q <= '0;
        end else if (idle_cnt_q != CNT_TOP) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    // Purpose: failure flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
        end else begin
            fail_q <= fail_d;
        end
    end

    assign fail        = fail_q;
    assign fail_change = fail_d ^ fail_q;
endmodule

// File: rtl/txmon_irq_regs.sv
// Module: enable, pending and read-back registers for the activity monitor.
// Pending bits latch every flag change and clear on a write of 1 to the pending
// address. A flag change at the same edge beats a clear. Read data is combinational.
// Assumes fail_change is asserted in the cycle before the flag register updates.
module txmon_irq_regs
    import txmon_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     status,
    input  logic [NUM_CH-1:0]     fail_change,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [NUM_CH-1:0]     reg_wdata,
    output logic [NUM_CH-1:0]     reg_rdata,
    output logic [NUM_CH-1:0]     pend,
    output logic [NUM_CH-1:0]     enable,
    output logic                  irq
);
    txmon_reg_e         addr_sel;
    logic [NUM_CH-1:0]  clr_mask;
    logic [NUM_CH-1:0]  pend_q;
    logic [NUM_CH-1:0]  en_q;

    assign addr_sel = txmon_reg_e'(reg_addr);

    // Purpose: bits the current write asks to clear in the pending register.
    assign clr_mask = (reg_wr && addr_sel == REG_PENDING) ? reg_wdata : '0;

    // Purpose: sticky pending bits; a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= fail_change | (pend_q & ~clr_mask);
        end
    end

    // Purpose: interrupt enable register, written at the enable address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (reg_wr && addr_sel == REG_ENABLE) begin
            en_q <= reg_wdata;
        end
    end

    // Purpose: read-back multiplexer over the register map.
    always_comb begin
        unique case (addr_sel)
            REG_STATUS:  reg_rdata = status;
            REG_ENABLE:  reg_rdata = en_q;
            REG_PENDING: reg_rdata = pend_q;
            default:     reg_rdata = '0;
        endcase
    end

    assign pend   = pend_q;
    assign enable = en_q;
    assign irq    = |(pend_q & en_q);
endmodule

// File: rtl/txdrv_activity_monitor.sv
// Module: top of the transmit driver activity monitor.
// Replicates one idle channel per transmit driver and shares one register and
// interrupt block across all channels.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module txdrv_activity_monitor
    import txmon_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int IDLE_LIMIT = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     tx_pos,
    input  logic [NUM_CH-1:0]     tx_neg,
    output logic [NUM_CH-1:0]     drv_fail,
    output logic                  irq,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [NUM_CH-1:0]     reg_wdata,
    output logic [NUM_CH-1:0]     reg_rdata
);
    logic [NUM_CH-1:0] fail_vec;
    logic [NUM_CH-1:0] change_vec;
    logic [NUM_CH-1:0] pend_vec;
    logic [NUM_CH-1:0] en_vec;

    // Purpose: one idle monitor per channel.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        txmon_idle_channel #(
            .IDLE_LIMIT (IDLE_LIMIT)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .pos_pulse   (tx_pos[ch]),
            .neg_pulse   (tx_neg[ch]),
            .fail        (fail_vec[ch]),
            .fail_change (change_vec[ch])
        );
    end

    // Purpose: shared pending, enable and read-back logic.
    txmon_irq_regs #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .status      (fail_vec),
        .fail_change (change_vec),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pend        (pend_vec),
        .enable      (en_vec),
        .irq         (irq)
    );

    assign drv_fail = fail_vec;
endmodule

// File: rtl/txmon_checker.sv
// Module: assertion checker for the transmit driver activity monitor.
// Keeps its own count of idle cycles per channel and checks the flags and
// pending bits against it and against the port activity. Bound to the top below.
module txmon_checker
    import txmon_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int IDLE_LIMIT = 128
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CH-1:0]     tx_pos,
    input logic [NUM_CH-1:0]     tx_neg,
    input logic [NUM_CH-1:0]     drv_fail,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  reg_wr,
    input logic [NUM_CH-1:0]     reg_wdata,
    input logic [NUM_CH-1:0]     pend
);
    localparam int CW = $clog2(IDLE_LIMIT + 2);
    localparam logic [CW-1:0] OVER = CW'(IDLE_LIMIT + 1);

    logic [NUM_CH-1:0] act;
    logic [NUM_CH-1:0] wr_clr;

    assign act    = tx_pos | tx_neg;
    assign wr_clr = (reg_wr && reg_addr == REG_PENDING) ? reg_wdata : '0;

    // R1: a reset edge leaves flags and pending bits cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (drv_fail == '0 && pend == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_win
        logic [CW-1:0] quiet_q;

        // Purpose: independent count of consecutive idle cycles, saturating above the limit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quiet_q <= '0;
            end else if (act[g]) begin
                quiet_q <= '0;
            end else if (quiet_q != OVER) begin
                quiet_q <= quiet_q + 1'b1;
            end
        end

        // R2: the flag is set exactly when more than the limit of idle cycles has passed.
        a_r2_fail_after_window: assert property (@(posedge clk) disable iff (!rst_n)
            drv_fail[g] == (quiet_q == OVER));
    end

    // R3: a pulse on either rail clears the flag at the next edge.
    a_r3_pulse_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (|act) |=> ((drv_fail & $past(act)) == '0));

    // R4: a set flag stays set while the channel remains silent.
    a_r4_fail_held_in_silence: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(drv_fail) & ~$past(act) & ~drv_fail) == '0));

    // R6: every flag change is latched in the pending bit at the same edge.
    a_r6_change_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((drv_fail ^ $past(drv_fail)) & ~pend) == '0));

    // R7: a pending bit only falls under a clearing write to that bit.
    a_r7_pending_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~pend & ~$past(wr_clr)) == '0));
endmodule

bind txdrv_activity_monitor txmon_checker #(
    .NUM_CH     (NUM_CH),
    .IDLE_LIMIT (IDLE_LIMIT)
) u_txmon_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_pos    (tx_pos),
    .tx_neg    (tx_neg),
    .drv_fail  (drv_fail),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend      (pend_vec)
);

// File: tb/test_txdrv_activity_monitor.sv
`timescale 1ns/1ps
// Bench: constrained random pulse traffic plus directed corner cases, checked
// against a reference model built from the requirements.
module test_txdrv_activity_monitor;
    localparam int NCH   = 8;
    localparam int LIMIT = 128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tx_pos = '0;
    logic [NCH-1:0] tx_neg = '0;
    logic [NCH-1:0] drv_fail;
    logic           irq;
    logic [1:0]     reg_addr = 2'd0;
    logic           reg_wr = 1'b0;
    logic [NCH-1:0] reg_wdata = '0;
    logic [NCH-1:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    int             m_cnt [NCH];
    logic [NCH-1:0] m_fail = '0;
    logic [NCH-1:0] m_pend = '0;
    logic [NCH-1:0] m_en   = '0;

    always #10 clk = ~clk;

    txdrv_activity_monitor #(.NUM_CH(NCH), .IDLE_LIMIT(LIMIT)) i_txdrv_activity_monitor (
        .clk(clk), .rst_n(rst_n), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .drv_fail(drv_fail), .irq(irq), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_pend & m_en);
    endfunction

    // Reference model step, from R2 R3 R4 R6 R7 R8 R9.
    task automatic model_step(input logic [NCH-1:0] p, input logic [NCH-1:0] n,
                              input logic wr, input logic [1:0] a, input logic [NCH-1:0] d);
        for (int i = 0; i < NCH; i++) begin
            logic pulse, nf, clr;
            pulse = p[i] | n[i];
            nf    = pulse ? 1'b0 : (m_fail[i] | (m_cnt[i] == LIMIT));
            m_cnt[i] = pulse ? 0 : ((m_cnt[i] == LIMIT) ? LIMIT : m_cnt[i] + 1);
            clr   = wr && a == 2'd2 && d[i];
            m_pend[i] = (nf != m_fail[i]) | (m_pend[i] & ~clr);
            m_fail[i] = nf;
        end
        if (wr && a == 2'd1) m_en = d;
    endtask

    // One clock: drive at negedge, model at posedge, compare at the next negedge.
    task automatic step(input logic [NCH-1:0] p, input logic [NCH-1:0] n,
                        input logic wr, input logic [1:0] a, input logic [NCH-1:0] d);
        tx_pos = p; tx_neg = n; reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        model_step(p, n, wr, a, d);
        @(negedge clk);
        reg_wr = 1'b0; tx_pos = '0; tx_neg = '0;
        check("R3 flag vector", drv_fail, m_fail);
        check("R9 irq", {7'd0, irq}, {7'd0, exp_irq()});
    endtask

    task automatic idle(input int cycles);
        for (int k = 0; k < cycles; k++) step('0, '0, 1'b0, 2'd0, '0);
    endtask

    task automatic read_chk(input string tag, input logic [1:0] a, input logic [NCH-1:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset.
        check("R1 drv_fail", drv_fail, '0);
        check("R1 irq", {7'd0, irq}, 8'd0);
        read_chk("R1 status", 2'd0, '0);
        read_chk("R1 enable", 2'd1, '0);
        read_chk("R1 pending", 2'd2, '0);

        // R2: 128 idle cycles leave flags low, the 129th raises them.
        idle(128);
        check("R2 boundary 128 idle", drv_fail, 8'h00);
        idle(1);
        check("R2 flag after 129 idle", drv_fail, 8'hFF);
        read_chk("R6 pending after rise", 2'd2, 8'hFF);

        // R4: long silence keeps the flag set.
        idle(300);
        check("R4 held in silence", drv_fail, 8'hFF);

        // R9: enable write and interrupt.
        step('0, '0, 1'b1, 2'd1, 8'h05);
        check("R9 irq with enable", {7'd0, irq}, 8'd1);
        read_chk("R9 enable readback", 2'd1, 8'h05);

        // R7: writing zeros keeps pending, writing ones clears.
        step('0, '0, 1'b1, 2'd2, 8'h00);
        read_chk("R7 zero write ignored", 2'd2, 8'hFF);
        step('0, '0, 1'b1, 2'd2, 8'h0F);
        read_chk("R7 clear low nibble", 2'd2, 8'hF0);
        check("R9 irq masked", {7'd0, irq}, 8'd0);

        // R3/R5: positive rail on ch2 only, then negative rail on ch3 only.
        step(8'h04, '0, 1'b0, 2'd0, '0);
        check("R5 only ch2 cleared", drv_fail, 8'hFB);
        read_chk("R6 pending on fall", 2'd2, 8'hF4);
        check("R9 irq from ch2", {7'd0, irq}, 8'd1);
        step('0, 8'h08, 1'b0, 2'd0, '0);
        check("R3 negative rail clears", drv_fail, 8'hF3);

        // R8: fall of ch0 coincides with a clear of ch0 pending.
        step(8'h01, '0, 1'b1, 2'd2, 8'h01);
        read_chk("R8 edge beats clear", 2'd2, m_pend);
        check("R8 ch0 pending set", {7'd0, m_pend[0]}, 8'd1);

        // R10: writes to status and spare addresses are ignored.
        step('0, '0, 1'b1, 2'd0, 8'h00);
        step('0, '0, 1'b1, 2'd3, 8'hFF);
        read_chk("R10 status map", 2'd0, m_fail);
        read_chk("R10 spare reads zero", 2'd3, 8'h00);
        read_chk("R10 enable untouched", 2'd1, 8'h05);

        // Random phase: mixed pulse densities and register traffic.
        for (int seg = 0; seg < 40; seg++) begin
            int dens [NCH];
            for (int i = 0; i < NCH; i++) begin
                case ($urandom % 4)
                    0: dens[i] = 0;
                    1: dens[i] = 2;
                    2: dens[i] = 20;
                    default: dens[i] = 200;
                endcase
            end
            for (int k = 0; k < 250; k++) begin
                logic [NCH-1:0] p, n;
                logic wr;
                logic [1:0] a;
                p = '0; n = '0;
                for (int i = 0; i < NCH; i++) begin
                    if (($urandom % 1000) < dens[i]) begin
                        if ($urandom % 2 == 0) p[i] = 1'b1; else n[i] = 1'b1;
                    end
                end
                wr = ($urandom % 20) == 0;
                a  = 2'($urandom % 4);
                step(p, n, wr, a, 8'($urandom));
            end
            read_chk("R10 status random", 2'd0, m_fail);
            read_chk("R9 enable random", 2'd1, m_en);
            read_chk("R7 pending random", 2'd2, m_pend);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule